// File: doc/BRIEF.md
# SPI Byte Controller with Collision-Detecting Select

This block is a full-duplex serial peripheral interface engine that moves one byte at a time and can run either as bus master or as bus slave. As master it produces the serial clock from the system clock through an even divider and shifts a byte out while it shifts one in. As slave it takes the serial clock and the active-low select from the bus, synchronizes them, and shifts only while it is selected. A small set of control strobes picks the role, loads the divider, hands over a transmit byte and clears the status flags. The received byte and a completion flag are returned.

In master mode one pin does one of three jobs, chosen by two control bits. It can be left alone as a general-purpose pin. It can be an automatic select output that falls for each byte and rises between bytes. Or it can be an input that watches for a second master. If that input is seen low, the block records a sticky fault, drops out of master mode and releases the clock and data outputs.

The bus uses a single fixed timing mode. The clock idles low, data goes out most significant bit first, outputs change on the falling edge and inputs are sampled on the rising edge.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset the block is in slave mode with done, wcol and fault at 0, all output enables at 0, sck_o at 0 and sel_o at 1.
- R2: In master mode a write to tx_byte starts a transfer of exactly eight serial clock cycles. The bytes are shifted most significant bit first and both directions move at once. At the end rx_byte holds the byte the slave sent, the slave's rx_byte holds the master's byte, and done is set after the eighth falling edge.
- R3: The master serial clock idles low. Its high and low phases each last H system clock cycles, with H = ctl_div/2 for an even ctl_div of at least 2. done therefore rises 16*H cycles after the write is accepted.
- R4: With ctl_nofault=1 and ctl_selout=1 in master mode, sel_oe is 1. sel_o is low from the cycle a transfer is accepted until it ends, and it is high between bytes.
- R5: With ctl_nofault=1 and ctl_selout=0 in master mode, sel_oe is 0 and a low level on sel_i has no effect: no fault is raised and the transfer completes.
- R6: With ctl_nofault=0 in master mode, a low level on sel_i sets a sticky fault flag, clears master_en, drops sck_oe and mosi_oe, and aborts the transfer without setting done. fault stays set until clr_fault.
- R7: In slave mode the block shifts only while sel_i is low, and drives miso_oe only then. Clock edges seen while sel_i is high leave done and rx_byte unchanged.
- R8: A tx_we while a transfer runs (master) or while selected (slave) is ignored and sets wcol. The bytes exchanged by the running transfer are unchanged.
- R9: done stays set until clr_flags is pulsed. clr_flags clears both done and wcol.
- R10: Fault detection acts only in master mode. A slave configured with ctl_nofault=0 and selected never raises fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Strobe that loads the four control fields below |
| ctl_master | input | 1 | 1 selects master mode |
| ctl_nofault | input | 1 | 1 disables collision detection on the select pin |
| ctl_selout | input | 1 | 1 makes the select pin an automatic output (when ctl_nofault=1) |
| ctl_div | input | DIV_W | System clocks per serial clock period (even, at least 2) |
| tx_we | input | 1 | Strobe that hands over a transmit byte |
| tx_byte | input | DATA_W | Byte to transmit |
| clr_flags | input | 1 | Clears done and wcol |
| clr_fault | input | 1 | Clears fault |
| rx_byte | output | DATA_W | Last received byte |
| done | output | 1 | Transfer complete, sticky |
| wcol | output | 1 | Write collision, sticky |
| fault | output | 1 | Master collision detected, sticky |
| busy | output | 1 | Transfer running or slave selected |
| master_en | output | 1 | Current mode is master |
| sck_o | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Master data in (slave) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Slave data in (master) |
| sel_o | output | 1 | Select out, active low |
| sel_oe | output | 1 | Select output enable |
| sel_i | input | 1 | Select in, active low |

## Verification
The bench wires two copies back to back, one master and one slave, and exchanges byte pairs at two divider settings. The pairs include all-zeros against all-ones, single set bits at either end and a stepped arithmetic series. Swapped or reversed bits then show up as a wrong byte on one side, and a wrong phase length shows up as a wrong cycle count. Separate runs put the select pin in each of its three master roles. Select is then held inactive on the slave, a second write is forced mid-transfer on both sides, and a second master is pulled in during a transfer. This separates select handling, collision flagging and the fault fallback from the plain data path.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;

  typedef enum logic [1:0] {
    SEL_GPIO  = 2'd0,
    SEL_AUTO  = 2'd1,
    SEL_FAULT = 2'd2
  } sel_role_e;

  // Role of the select pin while in master mode.
  function automatic sel_role_e sel_role(input logic nofault, input logic selout);
    if (!nofault) return SEL_FAULT;
    else if (selout) return SEL_AUTO;
    else return SEL_GPIO;
  endfunction

  // System clocks per serial clock phase; never below one.
  function automatic logic [15:0] half_of(input logic [15:0] div);
    return (div < 16'd2) ? 16'd1 : (div >> 1);
  endfunction

endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_mf_clkgen.sv
module spi_mf_clkgen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half,
  output logic          sck,
  output logic          rise,
  output logic          fall
);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == half - CW'(1));
  assign rise = tick && !sck;
  assign fall = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R3
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(sck));
  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck);
endmodule

// File: rtl/spi_mf_shift.sv
module spi_mf_shift #(
  parameter int DATA_W = 8,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              rise,
  input  logic              fall,
  input  logic              din,
  output logic              dout,
  output logic              last_fall,
  output logic [DATA_W-1:0] rx_val,
  output logic [CNT_W-1:0]  bit_idx
);
  logic [DATA_W-1:0] sh;
  logic              samp;
  logic              at_last;

  assign at_last   = (bit_idx == CNT_W'(DATA_W - 1));
  assign last_fall = fall && at_last;
  assign dout      = sh[DATA_W-1];
  assign rx_val    = {sh[DATA_W-2:0], samp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      samp    <= 1'b0;
      bit_idx <= '0;
    end else if (load) begin
      sh      <= load_val;
      bit_idx <= '0;
    end else if (clr) begin
      bit_idx <= '0;
    end else begin
      if (rise) samp <= din;
      if (fall) begin
        sh      <= {sh[DATA_W-2:0], samp};
        bit_idx <= at_last ? '0 : bit_idx + CNT_W'(1);
      end
    end
  end

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !load && !clr) |=> $stable(bit_idx));
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl #(
  parameter int DATA_W = 8,
  parameter int DIV_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_master,
  input  logic              ctl_nofault,
  input  logic              ctl_selout,
  input  logic [DIV_W-1:0]  ctl_div,
  input  logic              tx_we,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              clr_flags,
  input  logic              clr_fault,
  output logic [DATA_W-1:0] rx_byte,
  output logic              done,
  output logic              wcol,
  output logic              fault,
  output logic              busy,
  output logic              master_en,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              miso_i,
  output logic              sel_o,
  output logic              sel_oe,
  input  logic              sel_i
);
  import spi_mf_pkg::*;

  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  // control state
  logic             nofault_q, selout_q, busy_m_q;
  logic [DIV_W-1:0] div_q;
  sel_role_e        role;
  logic [DIV_W-1:0] half_len;

  // synchronized bus inputs
  logic sck_s, sel_s, mosi_s, sck_d, sel_d;

  // named events
  logic fault_evt, s_act, s_rise, s_fall, m_rise, m_fall, m_sck;
  logic sh_rise, sh_fall, sh_clr, tx_ok, start_m, wcol_evt, xfer_end;
  logic sh_dout, sh_din;
  logic [DATA_W-1:0] rx_val;
  logic [CNT_W-1:0]  bit_idx;

  assign role     = sel_role(nofault_q, selout_q);
  assign half_len = DIV_W'(half_of(16'(div_q)));

  spi_mf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_i, sel_i, mosi_i}),
    .q({sck_s, sel_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      sel_d <= 1'b1;
    end else begin
      sck_d <= sck_s;
      sel_d <= sel_s;
    end
  end

  assign fault_evt = master_en && (role == SEL_FAULT) && !sel_s;
  assign s_act     = !master_en && !sel_d;
  assign s_rise    = s_act && sck_s && !sck_d;
  assign s_fall    = s_act && !sck_s && sck_d;

  spi_mf_clkgen #(.CW(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy_m_q), .half(half_len),
    .sck(m_sck), .rise(m_rise), .fall(m_fall)
  );

  assign busy     = busy_m_q || s_act;
  assign wcol_evt = tx_we && busy;
  assign tx_ok    = tx_we && !busy && !fault_evt;
  assign start_m  = tx_ok && master_en;
  assign sh_rise  = master_en ? m_rise : s_rise;
  assign sh_fall  = master_en ? m_fall : s_fall;
  assign sh_din   = master_en ? miso_i : mosi_s;
  assign sh_clr   = fault_evt || (!master_en && sel_d);

  spi_mf_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load(tx_ok), .load_val(tx_byte),
    .rise(sh_rise), .fall(sh_fall), .din(sh_din),
    .dout(sh_dout), .last_fall(xfer_end), .rx_val(rx_val), .bit_idx(bit_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      nofault_q <= 1'b1;
      selout_q  <= 1'b0;
      div_q     <= DIV_W'(2);
      busy_m_q  <= 1'b0;
      done      <= 1'b0;
      wcol      <= 1'b0;
      fault     <= 1'b0;
      rx_byte   <= '0;
    end else begin
      if (fault_evt)   master_en <= 1'b0;
      else if (ctl_we) master_en <= ctl_master;
      if (ctl_we) begin
        nofault_q <= ctl_nofault;
        selout_q  <= ctl_selout;
        div_q     <= ctl_div;
      end
      if (fault_evt || !master_en) busy_m_q <= 1'b0;
      else if (start_m)            busy_m_q <= 1'b1;
      else if (xfer_end)           busy_m_q <= 1'b0;
      if (xfer_end)       done <= 1'b1;
      else if (clr_flags) done <= 1'b0;
      if (wcol_evt)       wcol <= 1'b1;
      else if (clr_flags) wcol <= 1'b0;
      if (fault_evt)      fault <= 1'b1;
      else if (clr_fault) fault <= 1'b0;
      if (xfer_end) rx_byte <= rx_val;
    end
  end

  assign sck_o   = master_en && m_sck;
  assign sck_oe  = master_en;
  assign mosi_o  = sh_dout;
  assign mosi_oe = master_en;
  assign miso_o  = sh_dout;
  assign miso_oe = s_act;
  assign sel_oe  = master_en && (role == SEL_AUTO);
  assign sel_o   = !(sel_oe && busy_m_q);

  // R2
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done);
  // R6
  fault_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (fault && !master_en && !sck_oe && !mosi_oe));
  // R8
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_evt |=> wcol);
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_flags) |=> done);
  // R4
  sel_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && sel_oe && !ctl_we) |=> sel_o);
  // R10
  slave_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_en && !ctl_we && !fault) |=> !fault);
endmodule

// File: tb/spi_mf_ctrl_bench.sv
module spi_mf_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int failed = 0;

  // master side
  logic m_ctl_we = 0, m_ctl_master = 0, m_ctl_nofault = 1, m_ctl_selout = 0;
  logic [7:0] m_ctl_div = 8'd2;
  logic m_tx_we = 0; logic [7:0] m_tx_byte = 0;
  logic m_clr_flags = 0, m_clr_fault = 0, m_sel_in = 1;
  logic [7:0] m_rx;
  logic m_done, m_wcol, m_fault, m_busy, m_master_en;
  logic m_sck_o, m_sck_oe, m_mosi_o, m_mosi_oe, m_miso_o, m_miso_oe, m_sel_o, m_sel_oe;
  // peer side
  logic s_ctl_we = 0, s_ctl_master = 0, s_ctl_nofault = 0, s_ctl_selout = 0;
  logic [7:0] s_ctl_div = 8'd2;
  logic s_tx_we = 0; logic [7:0] s_tx_byte = 0;
  logic s_clr_flags = 0, s_clr_fault = 0, s_sel_force = 1;
  logic [7:0] s_rx;
  logic s_done, s_wcol, s_fault, s_busy, s_master_en;
  logic s_sck_o, s_sck_oe, s_mosi_o, s_mosi_oe, s_miso_o, s_miso_oe, s_sel_o, s_sel_oe;
  logic s_sel_wire;

  assign s_sel_wire = m_sel_oe ? m_sel_o : s_sel_force;

  spi_mf_ctrl u_spi_mf_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_we(m_ctl_we), .ctl_master(m_ctl_master),
    .ctl_nofault(m_ctl_nofault), .ctl_selout(m_ctl_selout), .ctl_div(m_ctl_div),
    .tx_we(m_tx_we), .tx_byte(m_tx_byte), .clr_flags(m_clr_flags), .clr_fault(m_clr_fault),
    .rx_byte(m_rx), .done(m_done), .wcol(m_wcol), .fault(m_fault), .busy(m_busy),
    .master_en(m_master_en), .sck_o(m_sck_o), .sck_oe(m_sck_oe), .sck_i(1'b0),
    .mosi_o(m_mosi_o), .mosi_oe(m_mosi_oe), .mosi_i(1'b0),
    .miso_o(m_miso_o), .miso_oe(m_miso_oe), .miso_i(s_miso_o),
    .sel_o(m_sel_o), .sel_oe(m_sel_oe), .sel_i(m_sel_in)
  );

  spi_mf_ctrl u_spi_mf_ctrl_peer (
    .clk(clk), .rst_n(rst_n), .ctl_we(s_ctl_we), .ctl_master(s_ctl_master),
    .ctl_nofault(s_ctl_nofault), .ctl_selout(s_ctl_selout), .ctl_div(s_ctl_div),
    .tx_we(s_tx_we), .tx_byte(s_tx_byte), .clr_flags(s_clr_flags), .clr_fault(s_clr_fault),
    .rx_byte(s_rx), .done(s_done), .wcol(s_wcol), .fault(s_fault), .busy(s_busy),
    .master_en(s_master_en), .sck_o(s_sck_o), .sck_oe(s_sck_oe), .sck_i(m_sck_o),
    .mosi_o(s_mosi_o), .mosi_oe(s_mosi_oe), .mosi_i(m_mosi_o),
    .miso_o(s_miso_o), .miso_oe(s_miso_oe), .miso_i(1'b0),
    .sel_o(s_sel_o), .sel_oe(s_sel_oe), .sel_i(s_sel_wire)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_m(input bit ms, input bit nf, input bit so, input int dv);
    m_ctl_master = ms; m_ctl_nofault = nf; m_ctl_selout = so; m_ctl_div = dv[7:0];
    m_ctl_we = 1; tick(1); m_ctl_we = 0;
  endtask

  task automatic cfg_s(input bit nf);
    s_ctl_master = 0; s_ctl_nofault = nf; s_ctl_selout = 0; s_ctl_div = 8'd2;
    s_ctl_we = 1; tick(1); s_ctl_we = 0;
  endtask

  task automatic load_s(input logic [7:0] b);
    s_tx_byte = b; s_tx_we = 1; tick(1); s_tx_we = 0;
  endtask

  task automatic clr_all();
    m_clr_flags = 1; s_clr_flags = 1; tick(1); m_clr_flags = 0; s_clr_flags = 0;
  endtask

  // One exchange; h = serial clock phase length the requirements predict.
  task automatic do_xfer(input logic [7:0] mt, input logic [7:0] st, input int h,
                         input int collide, input bit auto_sel);
    int cnt, hi, rises;
    logic prev;
    if (auto_sel) load_s(st);
    m_tx_byte = mt; m_tx_we = 1; tick(1); m_tx_we = 0;
    if (auto_sel) check("R4 select low in byte", int'(m_sel_o), 0);
    cnt = 0; hi = 0; rises = 0; prev = 0;
    while (!m_done && cnt < 4000) begin
      if (collide > 0 && cnt == collide) begin
        m_tx_byte = ~mt; m_tx_we = 1; s_tx_byte = ~st; s_tx_we = 1;
      end else begin
        m_tx_we = 0; s_tx_we = 0;
      end
      tick(1);
      cnt++;
      if (m_sck_o) hi++;
      if (m_sck_o && !prev) rises++;
      prev = m_sck_o;
    end
    m_tx_we = 0; s_tx_we = 0;
    check("R3 cycles to done", cnt, 16 * h);
    check("R3 clock high cycles", hi, 8 * h);
    check("R2 eight clock cycles", rises, 8);
    check("R2 master received", int'(m_rx), int'(st));
    if (auto_sel) check("R4 select high between", int'(m_sel_o), 1);
    tick(6);
    check("R2 slave done", int'(s_done), 1);
    check("R2 slave received", int'(s_rx), int'(mt));
    check("R10 slave no fault", int'(s_fault), 0);
    if (collide > 0) begin
      check("R8 master wcol", int'(m_wcol), 1);
      check("R8 slave wcol", int'(s_wcol), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [7:0] prev_rx;
    tick(5);
    rst_n = 1;
    tick(1);
    // R1 reset state
    check("R1 master_en", int'(m_master_en), 0);
    check("R1 done", int'(m_done), 0);
    check("R1 wcol", int'(m_wcol), 0);
    check("R1 fault", int'(m_fault), 0);
    check("R1 oe", int'({m_sck_oe, m_mosi_oe, m_miso_oe, m_sel_oe}), 0);
    check("R1 sck_o", int'(m_sck_o), 0);
    check("R1 sel_o", int'(m_sel_o), 1);

    cfg_s(1'b0);
    // R2 R3 R4: sweep two dividers over corner and stepped bytes
    for (int dv = 8; dv <= 12; dv += 4) begin
      cfg_m(1, 1, 1, dv);
      check("R4 select output enabled", int'(m_sel_oe), 1);
      check("R1 master_en after config", int'(m_master_en), 1);
      do_xfer(8'h00, 8'hFF, dv / 2, 0, 1); clr_all();
      do_xfer(8'hFF, 8'h00, dv / 2, 0, 1); clr_all();
      do_xfer(8'h80, 8'h01, dv / 2, 0, 1); clr_all();
      do_xfer(8'h01, 8'h80, dv / 2, 0, 1); clr_all();
      for (int k = 0; k < 10; k++) begin
        do_xfer(8'((k * 53 + dv) & 255), 8'((k * 29 + 7) & 255), dv / 2, 0, 1);
        clr_all();
      end
    end

    // R9 done is sticky until cleared
    do_xfer(8'hA5, 8'h5A, 6, 0, 1);
    tick(20);
    check("R9 done held", int'(m_done), 1);
    clr_all();
    check("R9 done cleared", int'(m_done), 0);

    // R8 second write during a transfer on both ends
    do_xfer(8'h3C, 8'hC3, 6, 20, 1);
    clr_all();
    check("R9 wcol cleared", int'(m_wcol), 0);

    // R5 select left to general use; low input ignored
    cfg_m(1, 1, 0, 8);
    check("R5 select not driven", int'(m_sel_oe), 0);
    m_sel_in = 0;
    load_s(8'h96);
    s_sel_force = 0;
    tick(4);
    check("R7 miso driven when selected", int'(s_miso_oe), 1);
    do_xfer(8'h69, 8'h96, 4, 0, 0);
    check("R5 no fault", int'(m_fault), 0);
    check("R5 still master", int'(m_master_en), 1);
    s_sel_force = 1;
    m_sel_in = 1;
    tick(4);
    clr_all();

    // R7 slave not selected: no shifting
    prev_rx = s_rx;
    check("R7 miso released", int'(s_miso_oe), 0);
    m_tx_byte = 8'h5B; m_tx_we = 1; tick(1); m_tx_we = 0;
    for (int i = 0; i < 200 && !m_done; i++) tick(1);
    tick(6);
    check("R7 slave done stays low", int'(s_done), 0);
    check("R7 slave rx unchanged", int'(s_rx), int'(prev_rx));
    clr_all();

    // R6 collision with another master
    cfg_m(1, 0, 1, 8);
    check("R6 select not driven in fault role", int'(m_sel_oe), 0);
    tick(4);
    check("R6 no fault while select high", int'(m_fault), 0);
    m_tx_byte = 8'hE7; m_tx_we = 1; tick(1); m_tx_we = 0;
    tick(10);
    m_sel_in = 0;
    tick(5);
    check("R6 fault set", int'(m_fault), 1);
    check("R6 master dropped", int'(m_master_en), 0);
    check("R6 clock released", int'(m_sck_oe), 0);
    check("R6 data released", int'(m_mosi_oe), 0);
    m_sel_in = 1;
    tick(60);
    check("R6 aborted without done", int'(m_done), 0);
    check("R6 fault sticky", int'(m_fault), 1);
    m_clr_fault = 1; tick(1); m_clr_fault = 0;
    check("R6 fault cleared", int'(m_fault), 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule